// File: doc/BRIEF.md
# Gate Rail Power Sequencer

This controller sits beside the analog charge pumps of a multi-rail display supply. It watches an active-low shutdown input and a comparator flag that reports whether the negative gate rail has fallen past its -3 V threshold. From these it drives enables for the oscillator/timing generator, the logic-supply pump, the negative gate rail and the positive gate rail, together with an output-discharge enable and a one-cycle preset-load strobe for the DAC code latches.

When shutdown is released, the negative rail starts first. The positive rail is enabled only after the comparator flag has held true for a programmable number of consecutive clocks, which filters out glitches. If the flag never qualifies within a programmable timeout, the controller drops every rail, discharges the outputs and latches a fault. The fault clears only when shutdown is asserted again. Asserting shutdown in any state removes all enables in the same cycle and turns discharge on.

Top module: `gate_rail_seq`

## Requirements
- R1: Out of reset, osc_en, logic_en, neg_en, pos_en, preset_load and fault are 0 and dischg_en is 1.
- R2: While shdn_n is 0, osc_en, logic_en, neg_en and pos_en are 0 and dischg_en is 1 in that same cycle, whatever the state.
- R3: One clock edge after shdn_n is sampled high in the idle state with no fault, osc_en, logic_en and neg_en become 1 and dischg_en becomes 0, while pos_en stays 0.
- R4: pos_en rises only after neg_ok has been sampled high on QUAL_CYC consecutive edges in the waiting state. A low sample restarts the count.
- R5: Once pos_en is 1 it stays 1 whatever neg_ok does, until shdn_n goes low.
- R6: preset_load is a single-cycle pulse. It is high in exactly the first cycle after a shutdown release starts the rails.
- R7: If the rails are not qualified within TMO_CYC edges of waiting, all enables drop, dischg_en becomes 1 and fault becomes 1. They stay that way while shdn_n stays high. A low on shdn_n clears fault.
- R8: When qualification and timeout fall on the same edge, qualification wins: pos_en becomes 1 and fault stays 0.
- R9: neg_ok has no effect outside the waiting state. While idle or faulted, neg_ok high leaves every enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown request |
| neg_ok | input | 1 | Comparator: negative rail is beyond -3 V |
| osc_en | output | 1 | Oscillator/timing generator enable |
| logic_en | output | 1 | Logic-supply pump enable |
| neg_en | output | 1 | Negative gate rail enable |
| pos_en | output | 1 | Positive gate rail enable |
| dischg_en | output | 1 | Output discharge enable |
| preset_load | output | 1 | Strobe loading preset DAC codes |
| fault | output | 1 | Negative rail failed to qualify in time |

## Verification
The comparator flag is driven in several patterns: rising cleanly and staying high, chattering so that the qualify count must restart, never arriving, and arriving just in time or one cycle late against the timeout. Together these separate a correct debounce from a simple edge detector, and a correct timeout priority from an off-by-one. Shutdown is asserted while waiting, while running and while faulted. This shows that enables drop in the same cycle and that the fault clears. The comparator is also toggled while idle and while faulted to show that it is ignored there.

// File: rtl/gate_rail_seq.sv
module gate_rail_seq #(
  parameter int QUAL_CYC = 8,
  parameter int TMO_CYC  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic neg_ok,
  output logic osc_en,
  output logic logic_en,
  output logic neg_en,
  output logic pos_en,
  output logic dischg_en,
  output logic preset_load,
  output logic fault
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int TW = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {S_OFF, S_START, S_WAIT, S_RUN} st_t;
  st_t st;
  logic [QW-1:0] qcnt;
  logic [TW-1:0] tcnt;
  logic          flt;

  wire qual_hit = neg_ok && (qcnt == QW'(QUAL_CYC - 1));
  wire tmo_hit  = (tcnt == TW'(TMO_CYC - 1));
  wire live     = shdn_n && (st != S_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      qcnt <= '0;
      tcnt <= '0;
      flt  <= 1'b0;
    end else if (!shdn_n) begin
      st   <= S_OFF;
      qcnt <= '0;
      tcnt <= '0;
      flt  <= 1'b0;
    end else begin
      case (st)
        S_OFF:   if (!flt) st <= S_START;
        S_START: begin
          st   <= S_WAIT;
          qcnt <= '0;
          tcnt <= '0;
        end
        S_WAIT: begin
          if (qual_hit) st <= S_RUN;
          else if (tmo_hit) begin
            st  <= S_OFF;
            flt <= 1'b1;
          end
          qcnt <= neg_ok ? qcnt + 1'b1 : '0;
          tcnt <= tcnt + 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign osc_en      = live;
  assign logic_en    = live;
  assign neg_en      = live;
  assign dischg_en   = !live;
  assign pos_en      = shdn_n && (st == S_RUN);
  assign preset_load = shdn_n && (st == S_START);
  assign fault       = flt;

  // R2
  shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (!neg_en && !pos_en && !osc_en && dischg_en));
  // R4
  pos_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_en) |-> $past(neg_ok));
  // R3
  neg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_en |-> neg_en);
  // R6
  preset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> !preset_load);
  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!osc_en && !neg_en && dischg_en));
endmodule

// File: tb/sim_gate_rail_seq.sv
module sim_gate_rail_seq;
  localparam int CLK_P = 10;
  localparam int QC = 4;
  localparam int TC = 20;

  logic clk = 0, rst_n = 0, shdn_n = 0, neg_ok = 0;
  logic osc_en, logic_en, neg_en, pos_en, dischg_en, preset_load, fault;
  int checks = 0, fails = 0, cyc = 0;

  gate_rail_seq #(.QUAL_CYC(QC), .TMO_CYC(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .neg_ok(neg_ok),
    .osc_en(osc_en), .logic_en(logic_en), .neg_en(neg_en), .pos_en(pos_en),
    .dischg_en(dischg_en), .preset_load(preset_load), .fault(fault));

  always #(CLK_P/2) clk = ~clk;

  // reference model: phase 0 idle, 1 just started, 2 waiting, 3 running
  int ph = 0, okrun = 0, waited = 0;
  bit mflt = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !shdn_n) begin
      ph = 0; okrun = 0; waited = 0; mflt = 0;
    end else if (ph == 0) begin
      if (!mflt) ph = 1;
    end else if (ph == 1) begin
      ph = 2; okrun = 0; waited = 0;
    end else if (ph == 2) begin
      okrun = neg_ok ? okrun + 1 : 0;
      waited++;
      if (okrun >= QC) ph = 3;
      else if (waited >= TC) begin ph = 0; mflt = 1; end
    end
  end

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", rq, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit on;
    on = shdn_n && ph != 0;
    chk(shdn_n ? "R3 osc_en" : "R2 osc_en", osc_en, on);
    chk(shdn_n ? "R3 logic_en" : "R2 logic_en", logic_en, on);
    chk(shdn_n ? "R3 neg_en" : "R2 neg_en", neg_en, on);
    chk(shdn_n ? "R7 dischg_en" : "R2 dischg_en", dischg_en, !on);
    chk("R4/R5 pos_en", pos_en, shdn_n && ph == 3);
    chk("R6 preset_load", preset_load, shdn_n && ph == 1);
    chk("R7 fault", fault, mflt);
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    chk("R1 reset dischg", dischg_en, 1'b1);
    chk("R1 reset fault", fault, 1'b0);
    rst_n = 1; step(2);
    // R9 comparator ignored while idle
    neg_ok = 1; step(3);
    chk("R9 idle ignores neg_ok", neg_en, 1'b0);
    neg_ok = 0;
    // clean power-up
    shdn_n = 1; step(4); neg_ok = 1; step(8);
    chk("R4 qualified", pos_en, 1'b1);
    // R5 comparator drop in run
    neg_ok = 0; step(3); neg_ok = 1; step(1);
    chk("R5 stays running", pos_en, 1'b1);
    shdn_n = 0; step(3);
    // chattering comparator
    shdn_n = 1; neg_ok = 0; step(2);
    neg_ok = 1; step(2); neg_ok = 0; step(1); neg_ok = 1; step(3);
    chk("R4 restart count", pos_en, 1'b0);
    step(2);
    chk("R4 qualified after restart", pos_en, 1'b1);
    // shutdown while waiting
    shdn_n = 0; neg_ok = 0; step(2);
    shdn_n = 1; step(4); shdn_n = 0; step(2);
    // timeout and fault
    shdn_n = 1; step(TC + 4);
    chk("R7 fault set", fault, 1'b1);
    neg_ok = 1; step(6);
    chk("R9 faulted ignores neg_ok", neg_en, 1'b0);
    shdn_n = 0; neg_ok = 0; step(1);
    chk("R7 fault cleared", fault, 1'b0);
    // qualification exactly at timeout edge
    shdn_n = 1; step(2); step(TC - QC); neg_ok = 1; step(QC);
    chk("R8 qualify wins", pos_en, 1'b1);
    chk("R8 no fault", fault, 1'b0);
    shdn_n = 0; neg_ok = 0; step(2);
    // one cycle too late
    shdn_n = 1; step(2); step(TC - QC + 1); neg_ok = 1; step(QC);
    chk("R7 late is fault", fault, 1'b1);
    shdn_n = 0; step(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule